// File: doc/BRIEF.md
# Reset Cause Sequencer

This block merges the chip's reset sources into a single active-high core reset and keeps four status flags that tell firmware what caused the last reset or wake-up. The sources are a power-on detect, a brown-out detect, a watchdog time-out pulse and an active-low external reset pin. A sleep indication changes what a watchdog time-out or a pin reset means. The flags are a power-on flag, a brown-out flag, a time-out flag and a power-down flag. Firmware can set the power-on and brown-out flags to 1, so that the next event can be recognised when it clears one of them.

The external pin passes through a level filter, so a short low glitch is rejected. A power-up delay counter can stretch the reset that follows a power-on or a brown-out. A configuration input turns this delay on when it is 0. A second configuration input chooses whether the pin is used at all. The pin is only an input: nothing in the block drives it.

Top module: `rst_cause_seq`

## Requirements
- R1: While `por_i` is high, all state is cleared asynchronously. In that state `core_rst_o` is 1 and the flags {por,bor,to,pd} read 0,1,1,1. After a power-on the brown-out flag is defined to read 1.
- R2: Each clock edge with `bor_i` high clears the brown-out flag, sets TO and PD to 1, leaves the power-on flag as it was, and holds the core in reset.
- R3: A one-cycle `wdt_to_i` pulse while `sleep_i` is 0 clears TO. It leaves PD, POR and BOR unchanged. It asserts `core_rst_o` for exactly one cycle.
- R4: A `wdt_to_i` pulse while `sleep_i` is 1 clears both TO and PD. It leaves POR and BOR unchanged and does not assert `core_rst_o`.
- R5: A filtered pin reset resets the core. When `sleep_i` is 0 it leaves all four flags unchanged. When `sleep_i` is 1 it sets TO to 1 and clears PD.
- R6: `core_rst_o` stays high while any source is active. With no power-up delay it falls one clock after the last source is released. A pin-low or `bor_i` interval that lasts N sampled cycles therefore gives N cycles of reset.
- R7: When `pwrt_en_n_i` is 0, the reset that follows a power-on or a brown-out is held PWRT_CYCLES further cycles. When it is 1 there is no extra hold. A power-on with no delay releases the reset at the first clock edge. Watchdog and pin resets never get the delay.
- R8: A change of the pin level is accepted only after the raw level has differed from the accepted level for FILT_CYCLES consecutive clock edges. A low pulse shorter than FILT_CYCLES cycles causes no reset.
- R9: When `pin_en_i` is 0 the pin is ignored. Holding it low causes no reset and changes no flag.
- R10: A cycle with `sw_wr_i` high sets the POR flag if `sw_por_i` is 1 and the BOR flag if `sw_bor_i` is 1. A brown-out in the same cycle takes priority for BOR. TO and PD can never be changed by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on detect, active high, asynchronous clear |
| bor_i | input | 1 | Brown-out detect, active high |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| pin_n_i | input | 1 | External reset pin, active low |
| sleep_i | input | 1 | Core is in sleep mode |
| pwrt_en_n_i | input | 1 | Power-up delay enable, active low |
| pin_en_i | input | 1 | 1: pin used as reset input; 0: pin ignored |
| sw_wr_i | input | 1 | Firmware write strobe for the flags |
| sw_por_i | input | 1 | Write 1 to set the power-on flag |
| sw_bor_i | input | 1 | Write 1 to set the brown-out flag |
| core_rst_o | output | 1 | Core reset, active high |
| por_f_o | output | 1 | Power-on flag (0 after power-on) |
| bor_f_o | output | 1 | Brown-out flag (0 after brown-out) |
| to_f_o | output | 1 | Time-out flag (0 after watchdog event) |
| pd_f_o | output | 1 | Power-down flag (0 after an event in sleep) |

## Verification
The assertions treat all inputs as synchronous to `clk`, apart from `por_i`. They treat `wdt_to_i` as a pulse that arrives while `bor_i` is low. For the event checks, they also assume the filtered pin is not accepting an edge in the same cycle. The stimulus changes inputs only on falling edges. It keeps each event class separate, with enough idle cycles after each one for the filter and the delay counter to settle. `sleep_i` is held constant across each pin or watchdog event. The bench sweeps pulse lengths across the filter threshold and brown-out lengths with the delay both on and off. It computes the reset length from those lengths and the two parameters.

// File: rtl/rst_cause_seq.sv
module rst_cause_seq #(
  parameter int FILT_CYCLES = 4,
  parameter int PWRT_CYCLES = 64
) (
  input  logic clk,
  input  logic por_i,
  input  logic bor_i,
  input  logic wdt_to_i,
  input  logic pin_n_i,
  input  logic sleep_i,
  input  logic pwrt_en_n_i,
  input  logic pin_en_i,
  input  logic sw_wr_i,
  input  logic sw_por_i,
  input  logic sw_bor_i,
  output logic core_rst_o,
  output logic por_f_o,
  output logic bor_f_o,
  output logic to_f_o,
  output logic pd_f_o
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int PW = $clog2(PWRT_CYCLES + 1);

  logic          pin_raw, pin_f, pin_acc, pin_fall;
  logic [FW-1:0] fcnt;
  logic          wdt_run, wdt_slp, src, arm;
  logic [PW-1:0] dcnt, need;

  assign pin_raw  = pin_en_i ? pin_n_i : 1'b1;
  assign pin_acc  = (pin_raw != pin_f) && (fcnt == FW'(FILT_CYCLES - 1));
  assign pin_fall = pin_acc && !pin_raw;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      pin_f <= 1'b1;
      fcnt  <= '0;
    end else if (pin_raw == pin_f) begin
      fcnt <= '0;
    end else if (pin_acc) begin
      pin_f <= pin_raw;
      fcnt  <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign wdt_run = wdt_to_i && !sleep_i;
  assign wdt_slp = wdt_to_i && sleep_i;
  assign src     = bor_i || !pin_f || wdt_run;
  assign need    = (arm && !pwrt_en_n_i) ? PW'(PWRT_CYCLES) : '0;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      core_rst_o <= 1'b1;
      arm        <= 1'b1;
      dcnt       <= '0;
    end else if (src) begin
      core_rst_o <= 1'b1;
      dcnt       <= '0;
      if (bor_i) arm <= 1'b1;
    end else if (core_rst_o) begin
      if (dcnt >= need) begin
        core_rst_o <= 1'b0;
        arm        <= 1'b0;
        dcnt       <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      por_f_o <= 1'b0;
      bor_f_o <= 1'b1;
      to_f_o  <= 1'b1;
      pd_f_o  <= 1'b1;
    end else begin
      if (sw_wr_i && sw_por_i) por_f_o <= 1'b1;
      if (bor_i) begin
        bor_f_o <= 1'b0;
        to_f_o  <= 1'b1;
        pd_f_o  <= 1'b1;
      end else begin
        if (sw_wr_i && sw_bor_i) bor_f_o <= 1'b1;
        if (pin_fall && sleep_i) begin
          to_f_o <= 1'b1;
          pd_f_o <= 1'b0;
        end else if (wdt_run) begin
          to_f_o <= 1'b0;
        end else if (wdt_slp) begin
          to_f_o <= 1'b0;
          pd_f_o <= 1'b0;
        end
      end
    end
  end

  p_bor_flags_r2: assert property (@(posedge clk) disable iff (por_i)
    bor_i |=> (!bor_f_o && to_f_o && pd_f_o && core_rst_o));
  p_bor_keeps_por_r2: assert property (@(posedge clk) disable iff (por_i)
    (bor_i && !sw_wr_i) |=> $stable(por_f_o));
  p_wdt_run_r3: assert property (@(posedge clk) disable iff (por_i)
    (wdt_run && !bor_i) |=> (!to_f_o && core_rst_o && $stable(pd_f_o)));
  p_wdt_wake_r4: assert property (@(posedge clk) disable iff (por_i)
    (wdt_slp && !bor_i && !pin_acc && pin_f && !core_rst_o) |=>
      (!to_f_o && !pd_f_o && !core_rst_o));
  p_pin_sleep_r5: assert property (@(posedge clk) disable iff (por_i)
    (pin_fall && sleep_i && !bor_i) |=> (to_f_o && !pd_f_o));
  p_release_r6: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> !$past(src));
  p_hold_r6: assert property (@(posedge clk) disable iff (por_i)
    src |=> core_rst_o);
  p_filt_r8: assert property (@(posedge clk) disable iff (por_i)
    $fell(pin_f) |-> ($past(pin_raw) == 1'b0));
  p_filt_cnt_r8: assert property (@(posedge clk) disable iff (por_i)
    fcnt < FW'(FILT_CYCLES));
  p_pin_off_r9: assert property (@(posedge clk) disable iff (por_i)
    (!pin_en_i && pin_f) |=> pin_f);
  p_sw_no_to_r10: assert property (@(posedge clk) disable iff (por_i)
    (sw_wr_i && !bor_i && !pin_fall && !wdt_to_i) |=> ($stable(to_f_o) && $stable(pd_f_o)));
endmodule

// File: tb/rst_cause_seq_tb.sv
module rst_cause_seq_tb;
  localparam int F = 3;
  localparam int P = 8;
  localparam int TAIL = F + P + 4;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, wdt = 1'b0, pin_n = 1'b1, slp = 1'b0;
  logic en_n = 1'b0, pin_en = 1'b1, swr = 1'b0, swp = 1'b0, swb = 1'b0;
  logic core_rst, por_f, bor_f, to_f, pd_f;
  int checks = 0, fails = 0, hi = 0, wd = 0;

  always #2 clk = ~clk;

  rst_cause_seq #(.FILT_CYCLES(F), .PWRT_CYCLES(P)) u_dut (
    .clk(clk), .por_i(por), .bor_i(bor), .wdt_to_i(wdt), .pin_n_i(pin_n),
    .sleep_i(slp), .pwrt_en_n_i(en_n), .pin_en_i(pin_en), .sw_wr_i(swr),
    .sw_por_i(swp), .sw_bor_i(swb), .core_rst_o(core_rst), .por_f_o(por_f),
    .bor_f_o(bor_f), .to_f_o(to_f), .pd_f_o(pd_f));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    if (core_rst) hi++;
  endtask

  task automatic tail();
    repeat (TAIL) tick();
  endtask

  function automatic int flags();
    return {por_f, bor_f, to_f, pd_f};
  endfunction

  task automatic power_on(logic dly_off);
    @(negedge clk);
    en_n = dly_off; por = 1'b1;
    #1;
    chk("R1 reset during por", core_rst, 1);
    chk("R1 flags after por", flags(), 4'b0111);
    @(negedge clk);
    por = 1'b0; hi = 0;
    tail();
    chk("R7 power-on hold", hi, dly_off ? 0 : P);
  endtask

  task automatic sw_set();
    swr = 1'b1; swp = 1'b1; swb = 1'b1;
    tick();
    swr = 1'b0; swp = 1'b0; swb = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    power_on(1'b0);
    power_on(1'b1);

    sw_set();
    chk("R10 write sets POR/BOR", flags(), 4'b1111);

    for (int d = 0; d < 2; d++) begin
      for (int n = 1; n <= 3; n++) begin
        en_n = d[0]; hi = 0;
        bor = 1'b1;
        repeat (n) tick();
        bor = 1'b0;
        tail();
        chk("R2 R6 R7 brown-out hold", hi, n + (d == 0 ? P : 0));
        chk("R2 brown-out flags", flags(), 4'b1011);
        sw_set();
      end
    end
    en_n = 1'b0;

    hi = 0; wdt = 1'b1; tick(); wdt = 1'b0; tail();
    chk("R3 R7 watchdog run hold", hi, 1);
    chk("R3 watchdog run flags", flags(), 4'b1101);
    sw_set();
    chk("R10 write leaves TO", flags(), 4'b1101);

    slp = 1'b1; hi = 0;
    wdt = 1'b1; tick(); wdt = 1'b0; tail();
    chk("R4 watchdog wake no reset", hi, 0);
    chk("R4 watchdog wake flags", flags(), 4'b1100);
    slp = 1'b0;

    for (int l = 1; l <= F + 2; l++) begin
      hi = 0; pin_n = 1'b0;
      repeat (l) tick();
      pin_n = 1'b1;
      tail();
      chk("R8 R6 R7 pin pulse hold", hi, (l >= F) ? l : 0);
      chk("R5 pin run flags", flags(), 4'b1100);
    end

    slp = 1'b1; hi = 0; pin_n = 1'b0;
    repeat (F + 1) tick();
    pin_n = 1'b1; tail();
    chk("R5 pin sleep hold", hi, F + 1);
    chk("R5 pin sleep flags", flags(), 4'b1110);
    slp = 1'b0;

    pin_en = 1'b0; hi = 0; pin_n = 1'b0; slp = 1'b1;
    repeat (20) tick();
    pin_n = 1'b1; tail();
    chk("R9 pin disabled hold", hi, 0);
    chk("R9 pin disabled flags", flags(), 4'b1110);
    slp = 1'b0; pin_en = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule